// File: doc/BRIEF.md
# Single-Accumulator Word Processor Core

This block is a small stored-program processor built around one 16-bit accumulator and one link bit that holds the carry. It addresses 4096 words of 16 bits through a plain synchronous memory port. The port has an address, read data, write data and a write strobe, and read data is returned one clock after its address is shown. Each instruction runs as a fixed series of steps. A 4-bit step counter, decoded one-hot, moves through fetch, decode, an optional pointer step and execute. At the end of every instruction the counter returns to zero.

An instruction word holds an indirect flag, a 3-bit operation field and a 12-bit operand address. Seven operation codes act on memory. The eighth code selects a register operation, one bit per operation, or an input/output word, which this core treats as a no-op. A request input from an external interrupt block can take over the next fetch. When it does, the core saves the program counter at word 0 and continues at word 1. A halt operation freezes the core until the next reset.

Top module: `acc_cpu_core`

## Requirements
- R1: Word format: bit 15 is the indirect flag and bits 14..12 the operation (0 AND, 1 ADD, 2 LDA, 3 STA, 4 BUN, 5 BSA, 6 ISZ, 7 register/IO). Bits 11..0 are the address. The step counter never exceeds 6.
- R2: Fetch: in step 0 the PC is driven on `mem_addr`. Step 1 loads the instruction and adds one to the PC. Step 2 decodes the word. After reset the first fetch reads address 0.
- R3: With the indirect flag set, a memory operation replaces its address at step 3 with the low 12 bits of the word at that address. Indirect and direct forms take the same number of cycles.
- R4: AND and ADD combine the word at the address with the accumulator, and LDA loads it. ADD puts its carry-out in the link bit. Each takes 6 cycles.
- R5: STA writes the accumulator to the address, and BUN jumps to it. Each takes 5 cycles.
- R6: BSA writes the PC of the next instruction into the target word and continues at target+1. It takes 6 cycles.
- R7: ISZ increments the target word and writes it back. When the result is zero it skips the next instruction. It takes 7 cycles.
- R8: Register operations are chosen by a single set bit in bits 11..0: 11 clear AC, 10 clear link, 9 invert AC, 8 invert link, 7 rotate right through the link, 6 rotate left through the link, 5 increment AC, 4 skip if AC bit 15 is 0, 3 skip if AC bit 15 is 1, 2 skip if AC is 0, 1 skip if link is 0, 0 halt. Each takes 4 cycles.
- R9: After a halt, `halted` stays high, `mem_we` stays low and `mem_addr` does not change until reset.
- R10: Synchronous active-high reset clears the step counter, PC, halt state and all data registers. While reset is high, `mem_we` is low.
- R11: If `irq_req` is high in step 0, the core runs a 3-cycle interrupt sequence. It writes the PC to word 0, sets the PC to 1, and pulses `irq_ack` in its last cycle.
- R12: A word with operation 7 and the indirect flag set ends at step 3 (4 cycles) and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory word address |
| mem_rdata | input | 16 | Read data, valid one cycle after its address |
| mem_wdata | output | 16 | Write data |
| mem_we | output | 1 | Write strobe |
| irq_req | input | 1 | Interrupt request from the external interrupt block |
| irq_ack | output | 1 | High in the last cycle of the interrupt sequence |
| halted | output | 1 | High once a halt has run |

## Verification
The assertions assume the memory returns, one clock later, the word at the address shown. They also assume `irq_req` is lowered once `irq_ack` has been seen, and that register-operation words set at most one of bits 11..0. The bench satisfies all three. Its memory model registers the read data, it drops the request in the cycle where the acknowledge appears, and every register-operation word it builds has a single bit set. Under these conditions the step, write-slot and halt properties depend only on the core's own sequencing.

// File: rtl/acc_pkg.sv
package acc_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 12;
    localparam int SC_W   = 4;
    localparam int OP_W   = 3;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [OP_W-1:0] {
        OP_AND = 3'd0,
        OP_ADD = 3'd1,
        OP_LDA = 3'd2,
        OP_STA = 3'd3,
        OP_BUN = 3'd4,
        OP_BSA = 3'd5,
        OP_ISZ = 3'd6,
        OP_EXT = 3'd7
    } opcode_e;

    typedef enum logic [1:0] {
        CLS_MEM,
        CLS_REG,
        CLS_IO
    } iclass_e;

    typedef struct packed {
        iclass_e cls;
        logic    indir;
        opcode_e op;
    } dec_t;

    typedef enum logic [3:0] {
        ALU_PASS,
        ALU_AND,
        ALU_ADD,
        ALU_LOAD,
        ALU_CLR,
        ALU_CLE,
        ALU_CMA,
        ALU_CME,
        ALU_CIR,
        ALU_CIL,
        ALU_INC
    } alu_op_e;

    // skip mask order: [3] AC non-negative, [2] AC negative, [1] AC zero, [0] link zero
    typedef struct packed {
        alu_op_e    alu;
        logic [3:0] skip;
        logic       halt;
    } rr_t;

    // register-operation bit positions (encoding is behaviour)
    localparam int RB_CLA = 11;
    localparam int RB_CLE = 10;
    localparam int RB_CMA = 9;
    localparam int RB_CME = 8;
    localparam int RB_CIR = 7;
    localparam int RB_CIL = 6;
    localparam int RB_INC = 5;
    localparam int RB_SPA = 4;
    localparam int RB_SNA = 3;
    localparam int RB_SZA = 2;
    localparam int RB_SZE = 1;
    localparam int RB_HLT = 0;

    function automatic dec_t decode_top(input logic [OP_W:0] hi);
        dec_t d;
        d.indir = hi[OP_W];
        d.op    = opcode_e'(hi[OP_W-1:0]);
        if (d.op != OP_EXT)
            d.cls = CLS_MEM;
        else if (d.indir)
            d.cls = CLS_IO;
        else
            d.cls = CLS_REG;
        return d;
    endfunction
endpackage

// File: rtl/acc_step_ctr.sv
module acc_step_ctr #(
    parameter int SC_W = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   hold,
    input  logic                   clr,
    output logic [SC_W-1:0]        sc,
    output logic [(1<<SC_W)-1:0]   t
);
    localparam int STEPS = 1 << SC_W;

    always_ff @(posedge clk) begin
        if (rst)
            sc <= '0;
        else if (hold)
            sc <= sc;
        else if (clr)
            sc <= '0;
        else
            sc <= sc + SC_W'(1);
    end

    for (genvar i = 0; i < STEPS; i++) begin : g_strobe
        assign t[i] = (sc == SC_W'(i));
    end
endmodule

// File: rtl/acc_rr_dec.sv
module acc_rr_dec
    import acc_pkg::*;
#(
    parameter int ADDR_W_P = ADDR_W
) (
    input  logic [ADDR_W_P-1:0] bits,
    output rr_t                 rr
);
    always_comb begin
        rr.alu  = ALU_PASS;
        rr.skip = {bits[RB_SPA], bits[RB_SNA], bits[RB_SZA], bits[RB_SZE]};
        rr.halt = bits[RB_HLT];
        if (bits[RB_CLA])
            rr.alu = ALU_CLR;
        else if (bits[RB_CLE])
            rr.alu = ALU_CLE;
        else if (bits[RB_CMA])
            rr.alu = ALU_CMA;
        else if (bits[RB_CME])
            rr.alu = ALU_CME;
        else if (bits[RB_CIR])
            rr.alu = ALU_CIR;
        else if (bits[RB_CIL])
            rr.alu = ALU_CIL;
        else if (bits[RB_INC])
            rr.alu = ALU_INC;
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  alu_op_e      op,
    input  logic [W-1:0] ac,
    input  logic [W-1:0] dr,
    input  logic         e,
    output logic [W-1:0] ac_n,
    output logic         e_n
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        ac_n = ac;
        e_n  = e;
        case (op)
            ALU_AND:  ac_n = ac & dr;
            ALU_ADD:  {e_n, ac_n} = {1'b0, ac} + {1'b0, dr};
            ALU_LOAD: ac_n = dr;
            ALU_CLR:  ac_n = '0;
            ALU_CLE:  e_n = 1'b0;
            ALU_CMA:  ac_n = ~ac;
            ALU_CME:  e_n = ~e;
            ALU_CIR: begin
                ac_n = {e, ac[W-1:1]};
                e_n  = ac[0];
            end
            ALU_CIL: begin
                ac_n = {ac[W-2:0], e};
                e_n  = ac[W-1];
            end
            ALU_INC:  ac_n = ac + ONE;
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
    import acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic              irq_req,
    output logic              irq_ack,
    output logic              halted
);
    localparam int    STEPS = 1 << SC_W;
    localparam addr_t A_ONE = addr_t'(1);
    localparam word_t W_ONE = word_t'(1);

    // architectural state
    addr_t pc_q, ar_q;
    word_t ir_q, dr_q, ac_q;
    logic  e_q, halt_q, irq_q;

    // step sequencing
    logic [SC_W-1:0]  sc_q;
    logic [STEPS-1:0] t;
    logic             sc_clr;

    // next-state controls
    addr_t   pc_d, ar_d;
    word_t   ir_d, dr_d, wdata_c;
    logic    we_c, halt_set, irq_d, ack_c;
    alu_op_e alu_op;
    word_t   alu_ac;
    logic    alu_e;

    dec_t       dec;
    rr_t        rr;
    logic [3:0] cond;
    logic       skip_hit;

    acc_step_ctr #(.SC_W(SC_W)) i_step (
        .clk  (clk),
        .rst  (rst),
        .hold (halt_q),
        .clr  (sc_clr),
        .sc   (sc_q),
        .t    (t)
    );

    acc_rr_dec #(.ADDR_W_P(ADDR_W)) i_rr (
        .bits (ir_q[ADDR_W-1:0]),
        .rr   (rr)
    );

    acc_alu #(.W(WORD_W)) i_alu (
        .op   (alu_op),
        .ac   (ac_q),
        .dr   (dr_q),
        .e    (e_q),
        .ac_n (alu_ac),
        .e_n  (alu_e)
    );

    assign dec      = decode_top(ir_q[WORD_W-1:ADDR_W]);
    assign cond     = {~ac_q[WORD_W-1], ac_q[WORD_W-1], (ac_q == '0), ~e_q};
    assign skip_hit = |(rr.skip & cond);

    always_comb begin
        ar_d     = ar_q;
        pc_d     = pc_q;
        ir_d     = ir_q;
        dr_d     = dr_q;
        alu_op   = ALU_PASS;
        we_c     = 1'b0;
        wdata_c  = ac_q;
        sc_clr   = 1'b0;
        halt_set = 1'b0;
        irq_d    = irq_q;
        ack_c    = 1'b0;
        if (!halt_q) begin
            if (t[0]) begin
                if (irq_req) begin
                    ar_d  = '0;
                    irq_d = 1'b1;
                end else begin
                    ar_d = pc_q;
                end
            end else if (irq_q) begin
                if (t[1]) begin
                    we_c    = 1'b1;
                    wdata_c = {{(WORD_W-ADDR_W){1'b0}}, pc_q};
                    pc_d    = '0;
                end else if (t[2]) begin
                    pc_d   = pc_q + A_ONE;
                    irq_d  = 1'b0;
                    ack_c  = 1'b1;
                    sc_clr = 1'b1;
                end else begin
                    irq_d  = 1'b0;
                    sc_clr = 1'b1;
                end
            end else if (t[1]) begin
                ir_d = mem_rdata;
                pc_d = pc_q + A_ONE;
            end else if (t[2]) begin
                ar_d = ir_q[ADDR_W-1:0];
            end else if (t[3]) begin
                case (dec.cls)
                    CLS_MEM: begin
                        if (dec.indir)
                            ar_d = mem_rdata[ADDR_W-1:0];
                    end
                    CLS_REG: begin
                        alu_op   = rr.alu;
                        halt_set = rr.halt;
                        if (skip_hit)
                            pc_d = pc_q + A_ONE;
                        sc_clr = 1'b1;
                    end
                    default: sc_clr = 1'b1;
                endcase
            end else if (t[4]) begin
                case (dec.op)
                    OP_AND, OP_ADD, OP_LDA, OP_ISZ: dr_d = mem_rdata;
                    OP_STA: begin
                        we_c   = 1'b1;
                        sc_clr = 1'b1;
                    end
                    OP_BUN: begin
                        pc_d   = ar_q;
                        sc_clr = 1'b1;
                    end
                    OP_BSA: begin
                        we_c    = 1'b1;
                        wdata_c = {{(WORD_W-ADDR_W){1'b0}}, pc_q};
                        ar_d    = ar_q + A_ONE;
                    end
                    default: sc_clr = 1'b1;
                endcase
            end else if (t[5]) begin
                case (dec.op)
                    OP_AND: begin
                        alu_op = ALU_AND;
                        sc_clr = 1'b1;
                    end
                    OP_ADD: begin
                        alu_op = ALU_ADD;
                        sc_clr = 1'b1;
                    end
                    OP_LDA: begin
                        alu_op = ALU_LOAD;
                        sc_clr = 1'b1;
                    end
                    OP_BSA: begin
                        pc_d   = ar_q;
                        sc_clr = 1'b1;
                    end
                    OP_ISZ: dr_d = dr_q + W_ONE;
                    default: sc_clr = 1'b1;
                endcase
            end else if (t[6]) begin
                if (dec.op == OP_ISZ) begin
                    we_c    = 1'b1;
                    wdata_c = dr_q;
                    if (dr_q == '0)
                        pc_d = pc_q + A_ONE;
                end
                sc_clr = 1'b1;
            end else if (|t[STEPS-1:7]) begin
                sc_clr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            ar_q   <= '0;
            ir_q   <= '0;
            dr_q   <= '0;
            ac_q   <= '0;
            e_q    <= 1'b0;
            halt_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            pc_q   <= pc_d;
            ar_q   <= ar_d;
            ir_q   <= ir_d;
            dr_q   <= dr_d;
            ac_q   <= alu_ac;
            e_q    <= alu_e;
            halt_q <= halt_q | halt_set;
            irq_q  <= irq_d;
        end
    end

    assign mem_addr  = we_c ? ar_q : ar_d;
    assign mem_wdata = wdata_c;
    assign mem_we    = we_c;
    assign irq_ack   = ack_c;
    assign halted    = halt_q;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
    import acc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              halted,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              irq_ack,
    input logic [SC_W-1:0]   sc,
    input logic [ADDR_W-1:0] pc,
    input logic              in_irq
);
    assert_step_bound_R1: assert property (@(posedge clk) disable iff (rst)
        sc <= SC_W'(6));

    assert_fetch_incr_R2: assert property (@(posedge clk) disable iff (rst)
        (sc == SC_W'(1) && !in_irq && !halted) |=> (pc == $past(pc) + ADDR_W'(1)));

    assert_write_slot_R5: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (sc == SC_W'(4) || sc == SC_W'(6) || (sc == SC_W'(1) && in_irq)));

    assert_halt_freeze_R9: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && !mem_we && $stable(mem_addr)));

    assert_reset_clear_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sc == '0 && pc == '0 && !halted));

    assert_irq_exit_R11: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> (sc == '0 && !in_irq && pc == ADDR_W'(1)));
endmodule

bind acc_cpu_core acc_cpu_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .halted   (halted),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .irq_ack  (irq_ack),
    .sc       (sc_q),
    .pc       (pc_q),
    .in_irq   (irq_q)
);

// File: tb/test_acc_cpu_core.sv
module test_acc_cpu_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mem_addr;
    logic [15:0] mem_rdata;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic        irq_req = 1'b0;
    logic        irq_ack;
    logic        halted;

    int n_tests = 0;
    int n_fail  = 0;
    int acks    = 0;
    int cyc     = 0;

    logic [15:0] mem [256];
    logic        ld_en   = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;

    logic [15:0] vals [6] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};

    always #2.5ns clk = ~clk;

    acc_cpu_core i_acc_cpu_core (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .irq_req   (irq_req),
        .irq_ack   (irq_ack),
        .halted    (halted)
    );

    always @(posedge clk) begin
        if (ld_en)
            mem[ld_addr] <= ld_data;
        else if (mem_we)
            mem[mem_addr[7:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[7:0]];
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic poke(input int a, input logic [15:0] d);
        ld_en   = 1'b1;
        ld_addr = a[7:0];
        ld_data = d;
        @(negedge clk);
        ld_en   = 1'b0;
    endtask

    task automatic prep();
        rst = 1'b1;
        for (int i = 0; i < 256; i++) poke(i, 16'h0000);
        poke(8'h82, 16'hDEAD);
    endtask

    task automatic run();
        cyc  = 0;
        acks = 0;
        rst  = 1'b0;
        while (1) begin
            @(negedge clk);
            cyc++;
            if (irq_ack) begin
                acks++;
                irq_req = 1'b0;
            end
            if (halted) break;
            if (cyc > 3000) begin
                n_fail++;
                $display("FAIL watchdog: program did not reach halt");
                break;
            end
        end
    endtask

    initial begin
        #900us;
        n_fail++;
        $display("FAIL watchdog: bench timeout");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [16:0] s;
        logic [15:0] a, b, exp82;
        @(negedge clk);
        prep();
        // R10: reset state
        chk("R10 halted in reset", {31'b0, halted}, 32'd0);
        chk("R10 no write in reset", {31'b0, mem_we}, 32'd0);

        // R8 timing + R2 first fetch address
        prep();
        poke(0, 16'h7800);
        poke(1, 16'h7001);
        rst = 1'b0;
        #1ns;
        chk("R2 first fetch address", {20'b0, mem_addr}, 32'd0);
        run();
        chk("R8 CLA+HLT cycles", cyc, 32'd8);
        // R9 freeze after halt
        begin
            logic [11:0] a0;
            a0 = mem_addr;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (!halted || mem_we || mem_addr !== a0) begin
                    chk("R9 frozen after halt", {halted, mem_we, 18'b0, mem_addr}, {2'b10, 18'b0, a0});
                    break;
                end
            end
            chk("R9 halted held", {31'b0, halted}, 32'd1);
        end

        // R4 ADD sweep with carry to link
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 6; j++) begin
                a = vals[i];
                b = vals[j];
                prep();
                poke(8'h80, a);
                poke(8'h81, b);
                poke(0, 16'h2080);
                poke(1, 16'h1081);
                poke(2, 16'h3082);
                poke(3, 16'h7800);
                poke(4, 16'h7040);
                poke(5, 16'h3083);
                poke(6, 16'h7001);
                run();
                s = {1'b0, a} + {1'b0, b};
                chk("R4 ADD sum", {16'b0, mem[8'h82]}, {16'b0, s[15:0]});
                chk("R4 ADD carry", {16'b0, mem[8'h83]}, {31'b0, s[16]});
            end
        end

        // R3 indirect AND/LDA sweep
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 6; j++) begin
                a = vals[i];
                b = vals[j] ^ 16'h0F0F;
                prep();
                poke(8'h80, a);
                poke(8'h81, b);
                poke(8'h84, 16'h0080);
                poke(8'h85, 16'h0081);
                poke(0, 16'hA084);
                poke(1, 16'h8085);
                poke(2, 16'h3082);
                poke(3, 16'h7001);
                run();
                chk("R3 indirect AND", {16'b0, mem[8'h82]}, {16'b0, a & b});
            end
        end

        // R3 and R4 cycle counts: indirect and direct LDA equal
        prep();
        poke(8'h84, 16'h0080);
        poke(0, 16'hA084);
        poke(1, 16'h7001);
        run();
        chk("R3 indirect LDA cycles", cyc, 32'd10);
        prep();
        poke(0, 16'h2080);
        poke(1, 16'h7001);
        run();
        chk("R4 direct LDA cycles", cyc, 32'd10);

        // R8 rotate, complement, increment sweeps
        for (int i = 0; i < 6; i++) begin
            a = vals[i];
            prep();
            poke(8'h80, a);
            poke(0, 16'h2080);
            poke(1, 16'h7080);
            poke(2, 16'h3082);
            poke(3, 16'h7800);
            poke(4, 16'h7040);
            poke(5, 16'h3083);
            poke(6, 16'h7001);
            run();
            chk("R8 CIR value", {16'b0, mem[8'h82]}, {17'b0, a[15:1]});
            chk("R8 CIR link", {16'b0, mem[8'h83]}, {31'b0, a[0]});

            prep();
            poke(8'h80, a);
            poke(0, 16'h2080);
            poke(1, 16'h7100);
            poke(2, 16'h7040);
            poke(3, 16'h3082);
            poke(4, 16'h7001);
            run();
            chk("R8 CME+CIL", {16'b0, mem[8'h82]}, {16'b0, a[14:0], 1'b1});

            prep();
            poke(8'h80, a);
            poke(0, 16'h2080);
            poke(1, 16'h7200);
            poke(2, 16'h7020);
            poke(3, 16'h3082);
            poke(4, 16'h7001);
            run();
            chk("R8 CMA+INC", {16'b0, mem[8'h82]}, {16'b0, 16'h0000 - a});
        end

        // R8 skip sweep: bit 4 SPA, bit 3 SNA, bit 2 SZA
        for (int i = 0; i < 6; i++) begin
            for (int k = 0; k < 3; k++) begin
                logic sk;
                a = vals[i];
                sk = (k == 0) ? !a[15] : (k == 1) ? a[15] : (a == 16'h0000);
                prep();
                poke(8'h80, a);
                poke(0, 16'h2080);
                poke(1, 16'h7000 | (16'h0010 >> k));
                poke(2, 16'h3082);
                poke(3, 16'h7001);
                run();
                exp82 = sk ? 16'hDEAD : a;
                chk("R8 AC skip", {16'b0, mem[8'h82]}, {16'b0, exp82});
            end
        end

        // R8 SZE with link cleared vs set
        for (int k = 0; k < 2; k++) begin
            prep();
            poke(0, 16'h7100);
            poke(1, (k == 0) ? 16'h7400 : 16'h7800);
            poke(2, 16'h7002);
            poke(3, 16'h3082);
            poke(4, 16'h7001);
            run();
            exp82 = (k == 0) ? 16'hDEAD : 16'h0000;
            chk("R8 SZE", {16'b0, mem[8'h82]}, {16'b0, exp82});
        end

        // R7 ISZ
        for (int i = 0; i < 3; i++) begin
            logic [15:0] v;
            v = (i == 0) ? 16'hFFFF : (i == 1) ? 16'h0000 : 16'h0005;
            prep();
            poke(8'h80, v);
            poke(0, 16'h6080);
            poke(1, 16'h3082);
            poke(2, 16'h7001);
            run();
            chk("R7 ISZ word", {16'b0, mem[8'h80]}, {16'b0, v + 16'h0001});
            exp82 = (v == 16'hFFFF) ? 16'hDEAD : 16'h0000;
            chk("R7 ISZ skip", {16'b0, mem[8'h82]}, {16'b0, exp82});
            if (v == 16'hFFFF) chk("R7 ISZ cycles (skip)", cyc, 32'd11);
        end

        // R6 BSA and indirect return
        prep();
        poke(8'h80, 16'h0ACE);
        poke(0, 16'h5040);
        poke(1, 16'h7001);
        poke(8'h41, 16'h2080);
        poke(8'h42, 16'h3082);
        poke(8'h43, 16'hC040);
        run();
        chk("R6 BSA return word", {16'b0, mem[8'h40]}, 32'h0001);
        chk("R6 BSA body ran", {16'b0, mem[8'h82]}, 32'h0ACE);
        chk("R6 BSA total cycles", cyc, 32'd26);

        // R5 BUN and STA
        prep();
        poke(0, 16'h4002);
        poke(1, 16'h3082);
        poke(2, 16'h7001);
        run();
        chk("R5 BUN cycles", cyc, 32'd9);
        chk("R5 BUN skipped word", {16'b0, mem[8'h82]}, 32'hDEAD);
        prep();
        poke(0, 16'h3082);
        poke(1, 16'h7001);
        run();
        chk("R5 STA cycles", cyc, 32'd9);
        chk("R5 STA value", {16'b0, mem[8'h82]}, 32'h0000);

        // R12 IO-class word is a no-op
        prep();
        poke(8'h80, 16'h5A5A);
        poke(0, 16'h2080);
        poke(1, 16'hF800);
        poke(2, 16'h3082);
        poke(3, 16'h7001);
        run();
        chk("R12 IO no-op value", {16'b0, mem[8'h82]}, 32'h5A5A);
        chk("R12 IO no-op cycles", cyc, 32'd19);

        // R11 interrupt sequence
        prep();
        poke(0, 16'h5555);
        poke(8'h80, 16'h0BEE);
        poke(1, 16'h2080);
        poke(2, 16'h3082);
        poke(3, 16'h7001);
        irq_req = 1'b1;
        run();
        irq_req = 1'b0;
        chk("R11 saved PC at word 0", {16'b0, mem[0]}, 32'h0000);
        chk("R11 resumed at word 1", {16'b0, mem[8'h82]}, 32'h0BEE);
        chk("R11 one acknowledge", acks, 32'd1);
        chk("R11 total cycles", cyc, 32'd18);

        // R1 operation field: opcode 7 with I=0 is a register op (halts), not memory
        prep();
        poke(0, 16'h7001);
        run();
        chk("R1 opcode 7 I=0 register class", cyc, 32'd4);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule